// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block models a synchronous static RAM whose data bus never needs an idle cycle between a read and a write. Each enabled rising clock edge registers an address, chip selects and a cycle type. A read returns its word one enabled edge after it is registered, through an output register. A write takes its data two enabled edges after its command. Because both kinds of cycle put their data on the bus at the same pipeline position, a controller can issue any mix of reads and writes on consecutive cycles.

The 36-bit word is split into four 9-bit lanes, and each write masks them lane by lane. A load cycle starts a four-beat burst. Advance cycles then step a 2-bit beat counter that forms the two lowest address bits, in either a wrapping linear order or an XOR order. A clock enable freezes every register. An output enable gates the read bus combinationally. A sleep input turns the outputs off at once and freezes the block while it is high. The array is small and its size is set by parameters.

Top module: `noturn_sram`

## Requirements
- R1: After reset is released, `rdata_drv` is 0, `rdata` is all zero, no burst is active and no write is pending.
- R2: While `clk_en` is 0, no register changes. A read result already on the bus stays there, and a pending write waits for enabled edges.
- R3: A load cycle (`adv`=0) selects the block only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect: nothing is written, no read result is produced, and any active burst ends.
- R4: A selected load cycle with `wr`=1 is a write. Its data is taken from `wdata` at the second enabled edge after the command edge. Lane i is bits [9i+8:9i] and is written only if `lane_we[i]`=1. The lane enables are sampled with the command.
- R5: A read command registered at enabled edge n drives the stored word on `rdata`, with `rdata_drv`=1, between enabled edges n+1 and n+2 (with `oe`=1 and `sleep`=0).
- R6: An advance cycle (`adv`=1) continues the cycle type of the last load, ignoring `wr` and the chip selects. The beat counter steps modulo 4 and wraps indefinitely, and the upper address bits stay at the load address.
- R7: With `interleave`=0, the low two address bits of a beat are (start + beat) mod 4.
- R8: With `interleave`=1, the low two address bits of a beat are start XOR beat.
- R9: Reads and writes can follow each other on consecutive cycles. A read of the address written by the immediately preceding command returns the new lanes merged over the old word.
- R10: `oe`=0 forces `rdata_drv` to 0 and `rdata` to zero combinationally. Raising `oe` again shows the held read word.
- R11: While `sleep` is 1, the outputs are off and the block ignores all commands, as if the clock were disabled.
- R12: An advance cycle with no active burst (after reset or after a deselect) does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clk_en | input | 1 | Clock enable; 0 freezes the block |
| sleep | input | 1 | Asynchronous power-down request |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| wr | input | 1 | Cycle type on load: 1 write, 0 read |
| interleave | input | 1 | Static burst order: 0 linear, 1 XOR |
| addr | input | 6 | Word address |
| lane_we | input | 4 | Per-lane write enables |
| wdata | input | 36 | Write data, two enabled cycles after its command |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | 36 | Read data, zero when not driven |
| rdata_drv | output | 1 | High while `rdata` carries a read word |

## Verification
The assertions assume that `interleave` changes only while no burst is active and that every input settles well away from the rising edge. They also assume that `wdata` is meaningful only in a write's data slot, and that no word is read before it has been written, since the array has no reset. The stimulus keeps to these assumptions. It fills every address with bursts before any read, and it changes the burst order only after a deselect. It changes inputs only at the falling edge and puts random junk on `wdata` in every slot that carries no write. Clock-enable and sleep windows fall between a command and its data slot, so the held pipeline state is exercised.

// File: rtl/nts_pkg.sv
package nts_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } nts_op_e;

  // low address bits of a burst beat
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/nts_ctrl.sv
module nts_ctrl
  import nts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv,
  input  logic              sel_ok,
  input  logic              wr,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we,
  output nts_op_e           s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_lanes
);

  localparam int HI_W = ADDR_W - 2;

  nts_op_e           btype_q, btype_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  nts_op_e           op_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    btype_d = btype_q;
    base_d  = base_q;
    beat_d  = beat_q;
    op_d    = OP_IDLE;
    addr_d  = s1_addr;
    if (!adv) begin
      if (sel_ok) begin
        base_d  = addr;
        beat_d  = 2'd0;
        btype_d = wr ? OP_WRITE : OP_READ;
        op_d    = btype_d;
        addr_d  = addr;
      end else begin
        btype_d = OP_IDLE;
      end
    end else if (btype_q != OP_IDLE) begin
      beat_d = beat_q + 2'd1;
      addr_d = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], beat_d, interleave)};
      op_d   = btype_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btype_q  <= OP_IDLE;
      base_q   <= '0;
      beat_q   <= '0;
      s1_op    <= OP_IDLE;
      s1_addr  <= '0;
      s1_lanes <= '0;
    end else if (en) begin
      btype_q  <= btype_d;
      base_q   <= base_d;
      beat_q   <= beat_d;
      s1_op    <= op_d;
      s1_addr  <= addr_d;
      s1_lanes <= lane_we;
    end
  end

  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(s1_op) && $stable(s1_addr)));

  a_r3_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv && !sel_ok) |=> (s1_op == OP_IDLE));

  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv && btype_q != OP_IDLE)
      |=> (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

  a_r12_adv_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv && btype_q == OP_IDLE) |=> (s1_op == OP_IDLE));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = base_q[ADDR_W-1:2];

endmodule

// File: rtl/nts_array.sv
module nts_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        wlanes,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rword
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wlanes[g]) begin
        mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rword[g*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/nts_outq.sv
module nts_outq #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    rd,
  input  logic [ADDR_W-1:0]       raddr,
  input  logic [LANES*LANE_W-1:0] arr_word,
  input  logic                    s2_wr,
  input  logic [ADDR_W-1:0]       s2_addr,
  input  logic [LANES-1:0]        s2_lanes,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_drv
);

  localparam int DATA_W = LANES * LANE_W;

  logic              fwd_hit;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] q_data;
  logic              q_drv;
  logic              drive;

  assign fwd_hit = s2_wr && (s2_addr == raddr);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (fwd_hit && s2_lanes[g])
                                      ? wdata[g*LANE_W +: LANE_W]
                                      : arr_word[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_drv  <= 1'b0;
      q_data <= '0;
    end else if (en) begin
      q_drv <= rd;
      if (rd) begin
        q_data <= merged;
      end
    end
  end

  assign drive     = q_drv && oe && !sleep;
  assign rdata_drv = drive;
  assign rdata     = drive ? q_data : '0;

  a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_drv |-> (rdata == '0));

  a_r5_read_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd) |=> q_drv);

  a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(q_data) && $stable(q_drv)));

endmodule

// File: rtl/noturn_sram.sv
module noturn_sram
  import nts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    sleep,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    adv,
  input  logic                    wr,
  input  logic                    interleave,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_drv
);

  localparam int DATA_W = LANES * LANE_W;

  logic [1:0]        rs_q;
  logic              rst_core_n;
  logic              en;
  logic              sel_ok;
  nts_op_e           s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_lanes;
  logic              s2_wr;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_lanes;
  logic [DATA_W-1:0] arr_word;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign en     = clk_en && !sleep;
  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  nts_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .en         (en),
    .adv        (adv),
    .sel_ok     (sel_ok),
    .wr         (wr),
    .interleave (interleave),
    .addr       (addr),
    .lane_we    (lane_we),
    .s1_op      (s1_op),
    .s1_addr    (s1_addr),
    .s1_lanes   (s1_lanes)
  );

  // write address stage: waits for the data slot
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      s2_wr    <= 1'b0;
      s2_addr  <= '0;
      s2_lanes <= '0;
    end else if (en) begin
      s2_wr    <= (s1_op == OP_WRITE);
      s2_addr  <= s1_addr;
      s2_lanes <= s1_lanes;
    end
  end

  nts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk    (clk),
    .we     (en && s2_wr),
    .waddr  (s2_addr),
    .wlanes (s2_lanes),
    .wdata  (wdata),
    .raddr  (s1_addr),
    .rword  (arr_word)
  );

  nts_outq #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_outq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .en        (en),
    .rd        (s1_op == OP_READ),
    .raddr     (s1_addr),
    .arr_word  (arr_word),
    .s2_wr     (s2_wr),
    .s2_addr   (s2_addr),
    .s2_lanes  (s2_lanes),
    .wdata     (wdata),
    .oe        (oe),
    .sleep     (sleep),
    .rdata     (rdata),
    .rdata_drv (rdata_drv)
  );

  a_r4_write_slot: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en && s1_op == OP_WRITE) |=> s2_wr);

  a_r11_sleep_freeze: assert property (@(posedge clk) disable iff (!rst_core_n)
    sleep |=> ($stable(s2_wr) && $stable(s2_addr)));

endmodule

// File: tb/sim_noturn_sram.sv
`timescale 1ns/1ps
module sim_noturn_sram;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1, sleep = 1'b0;
  logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic        adv = 1'b0, wr = 1'b0, ilv = 1'b0, oe = 1'b1;
  logic [5:0]  addr = '0;
  logic [3:0]  lane_we = '0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        rdata_drv;

  always #2.5 clk = ~clk;

  noturn_sram u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .adv(adv), .wr(wr), .interleave(ilv), .addr(addr),
    .lane_we(lane_we), .wdata(wdata), .oe(oe),
    .rdata(rdata), .rdata_drv(rdata_drv)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // scoreboard queues, one entry per clock edge
  logic [35:0] q_data[$];
  bit          q_drv[$];
  string       q_tag[$];

  // reference model
  logic [35:0] ref_mem [64];
  int          p1_op = 0, p2_op = 0;
  int          p1_addr = 0, p2_addr = 0;
  logic [3:0]  p1_ln = '0, p2_ln = '0;
  logic [35:0] p1_dat = '0, p2_dat = '0;
  logic [35:0] m_out = '0;
  bit          m_drv = 1'b0;
  int          b_type = 0, b_base = 0, b_beat = 0;

  localparam logic [2:0] SEL = 3'b010; // {sel_a_n, sel_b, sel_c_n}
  localparam logic [2:0] DES = 3'b000;

  task automatic step(input bit ce, input bit slp, input bit o, input bit ad,
                      input logic [2:0] sel, input bit w, input int a,
                      input logic [3:0] ln, input string tag);
    int c_op, c_addr, lo;
    logic [35:0] c_dat;
    @(negedge clk);
    clk_en = ce; sleep = slp; oe = o; adv = ad; wr = w;
    {sel_a_n, sel_b, sel_c_n} = sel;
    addr = a[5:0]; lane_we = ln;
    wdata = (p2_op == 2) ? p2_dat : {$urandom, $urandom};
    if (ce && !slp) begin
      if (p2_op == 2)
        for (int g = 0; g < 4; g++)
          if (p2_ln[g]) ref_mem[p2_addr][g*9 +: 9] = p2_dat[g*9 +: 9];
      if (p1_op == 1) begin m_out = ref_mem[p1_addr]; m_drv = 1'b1; end
      else m_drv = 1'b0;
      c_op = 0; c_addr = p1_addr;
      if (!ad) begin
        if (sel == SEL) begin
          b_base = a; b_beat = 0; b_type = w ? 2 : 1;
          c_op = b_type; c_addr = a;
        end else b_type = 0;
      end else if (b_type != 0) begin
        b_beat = (b_beat + 1) % 4;
        lo = ilv ? ((b_base % 4) ^ b_beat) : ((b_base + b_beat) % 4);
        c_addr = (b_base / 4) * 4 + lo;
        c_op = b_type;
      end
      c_dat = {$urandom, $urandom};
      p2_op = p1_op; p2_addr = p1_addr; p2_ln = p1_ln; p2_dat = p1_dat;
      p1_op = c_op; p1_addr = c_addr; p1_ln = ln; p1_dat = c_dat;
    end
    q_drv.push_back(m_drv && o && !slp);
    q_data.push_back((m_drv && o && !slp) ? m_out : 36'h0);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 1, 0, DES, 0, 0, 4'h0, tag);
  endtask

  task automatic burst(input bit w, input int a, input int beats,
                       input logic [3:0] ln, input string tag);
    step(1, 0, 1, 0, SEL, w, a, ln, tag);
    for (int i = 1; i < beats; i++) step(1, 0, 1, 1, DES, ~w, 0, ln, tag);
  endtask

  // monitor: compares after every edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_tag.size() > 0) begin
        logic [35:0] ed;
        bit ev;
        string t;
        ed = q_data.pop_front(); ev = q_drv.pop_front(); t = q_tag.pop_front();
        checks++;
        if (rdata !== ed || rdata_drv !== ev) begin
          failures++;
          $display("FAIL %s: rdata=%h drv=%b expected rdata=%h drv=%b",
                   t, rdata, rdata_drv, ed, ev);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    checks++; // R1 reset state
    if (rdata_drv !== 1'b0 || rdata !== 36'h0) begin
      failures++;
      $display("FAIL R1: rdata=%h drv=%b expected rdata=0 drv=0", rdata, rdata_drv);
    end
    idle(2, "R1");
    // R12: advance right after reset is a no-op
    step(1, 0, 1, 1, SEL, 1, 0, 4'hF, "R12");
    idle(2, "R12");

    // fill the array with linear write bursts (R4, R7)
    for (int b = 0; b < 16; b++) burst(1, b * 4, 4, 4'hF, "R4");
    idle(2, "R4");

    // R7 linear read from start low=1, then R6 wrap for four more beats
    burst(0, 5, 4, 4'h0, "R7");
    for (int i = 0; i < 4; i++) step(1, 0, 1, 1, 3'b101, 1, 0, 4'h0, "R6");
    idle(2, "R7");

    // R8 interleaved order
    ilv = 1'b1;
    burst(0, 10, 4, 4'h0, "R8");
    burst(1, 39, 4, 4'b1010, "R8");
    idle(2, "R8");
    burst(0, 39, 4, 4'h0, "R8");
    burst(0, 13, 6, 4'h0, "R8");
    idle(2, "R8");
    ilv = 1'b0;

    // R9 read immediately after a partial write to the same address
    step(1, 0, 1, 0, SEL, 1, 20, 4'b0101, "R9");
    step(1, 0, 1, 0, SEL, 0, 20, 4'h0, "R9");
    step(1, 0, 1, 0, SEL, 1, 21, 4'b1000, "R9");
    step(1, 0, 1, 0, SEL, 1, 21, 4'b0011, "R9");
    step(1, 0, 1, 0, SEL, 0, 21, 4'h0, "R9");
    for (int i = 0; i < 60; i++)
      step(1, 0, 1, 0, SEL, $urandom_range(0, 1), $urandom_range(16, 23),
           4'($urandom), "R9");
    idle(2, "R9");

    // R3 deselected writes change nothing
    step(1, 0, 1, 0, 3'b110, 1, 30, 4'hF, "R3");
    step(1, 0, 1, 0, 3'b000, 1, 30, 4'hF, "R3");
    step(1, 0, 1, 0, 3'b011, 1, 30, 4'hF, "R3");
    // R12 advance after a deselect does nothing
    step(1, 0, 1, 1, SEL, 1, 30, 4'hF, "R12");
    idle(2, "R3");
    burst(0, 28, 4, 4'h0, "R3");
    idle(2, "R3");

    // R2 suspension between command and data slots
    step(1, 0, 1, 0, SEL, 1, 44, 4'hF, "R2");
    step(1, 0, 1, 0, SEL, 0, 45, 4'h0, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, SEL, 1, 9, 4'hF, "R2");
    step(1, 0, 1, 0, SEL, 0, 44, 4'h0, "R2");
    for (int i = 0; i < 2; i++) step(0, 0, 1, 1, DES, 0, 0, 4'h0, "R2");
    idle(3, "R2");

    // R10 output enable gating
    step(1, 0, 1, 0, SEL, 0, 3, 4'h0, "R10");
    step(1, 0, 0, 0, SEL, 0, 4, 4'h0, "R10");
    step(0, 0, 0, 0, DES, 0, 0, 4'h0, "R10");
    step(0, 0, 1, 0, DES, 0, 0, 4'h0, "R10");
    idle(2, "R10");

    // R11 sleep: outputs off and commands ignored
    step(1, 0, 1, 0, SEL, 0, 50, 4'h0, "R11");
    step(1, 0, 1, 0, SEL, 1, 51, 4'hF, "R11");
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, SEL, 1, 50, 4'hF, "R11");
    step(1, 0, 1, 0, SEL, 0, 51, 4'h0, "R11");
    step(1, 0, 1, 0, SEL, 0, 50, 4'h0, "R11");
    idle(3, "R11");

    // R5 a plain read per address across the array
    for (int i = 0; i < 64; i += 7) step(1, 0, 1, 0, SEL, 0, i, 4'h0, "R5");
    idle(3, "R5");

    wait (q_tag.size() == 0);
    @(posedge clk); #3;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule